// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is a 16-bit up/down timer that makes center-aligned pulse-width modulation. On each timer tick the counter steps once. It climbs from zero to a TOP value, stays at TOP for one tick, and then walks back down to zero. TOP comes from one of two places. It is either a fixed-period register that takes writes at once, or the live compare value of channel 0.

Each compare channel keeps a write buffer and a live compare value. The live value is refreshed from the buffer only on the tick where the counter sits at zero. Because of this, the rising and falling halves of every period always use the same compare and TOP values, and every pulse stays symmetric about the period centre.

Each channel drives one pin, in normal or inverted polarity. The block also keeps sticky event flags for the bottom turn, the TOP turn and each channel match. Software clears a flag by writing a one to it.

Top module: `dspwm_timer`

## Requirements
- R1: The counter changes only in a cycle where `tick` is high. It steps 0, 1, ..., TOP, TOP-1, ..., 1, 0, 1, ... and holds TOP for a single tick. While counting up, if the counter is found at or above TOP, the next value is the counter minus one and the slope turns to down. When TOP is 0 the counter stays at 0. `count_down` reads 1 on the falling slope and 0 on the rising slope.
- R2: With `top_sel` = 0, TOP is the fixed-period register. A write through `fix_we`/`fix_wdata` takes effect from the next cycle. With `top_sel` = 1, TOP is the live compare value of channel 0.
- R3: `cmp_we[i]` writes `cmp_wdata` only into the buffer of channel i. The live compare value of channel i takes the buffer contents only on a tick where the counter is 0. If a buffer write lands in that same cycle, the live value gets the older buffer contents.
- R4: `flags[0]` (overflow) is set by a tick where the counter is 0. This is the same tick that reloads the live compare values.
- R5: A tick with the counter on the rising slope, nonzero and equal to TOP is the TOP event. It sets `flags[1]` when `top_sel` = 0 and `flags[2]` when `top_sel` = 1.
- R6: `flags[2+i]` is set by every tick where the counter equals the live compare value of channel i. If that value is above TOP, the flag is never set.
- R7: `out_mode[2i+1:2i]` selects how pin i behaves. Value 2 gives normal polarity: a match drives the pin low on the rising slope and high on the falling slope. Value 3 does the reverse. Values 0 and 1 hold the pin low.
- R8: The flags are sticky. A one in bit k of `flag_clr` clears flag k. If a clear and a set event hit the same flag in the same cycle, the flag ends up set.
- R9: Synchronous reset brings the counter, slope, fixed-period register, buffers, live compare values, pins and flags all to zero. The slope resets to rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable, one count step per high cycle |
| top_sel | input | 1 | TOP source: 0 fixed-period register, 1 channel 0 live compare |
| fix_we | input | 1 | Write strobe for the fixed-period register |
| fix_wdata | input | 16 | Fixed-period write data |
| cmp_we | input | NUM_CH | Per-channel compare buffer write strobes |
| cmp_wdata | input | 16 | Shared compare write data |
| out_mode | input | 2*NUM_CH | Two output-mode bits per channel |
| flag_clr | input | NUM_CH+2 | Write-one-to-clear for the flags |
| count | output | 16 | Counter value |
| count_down | output | 1 | Slope, 1 on the falling half |
| pwm_out | output | NUM_CH | PWM pins |
| flags | output | NUM_CH+2 | Bit 0 overflow, bit 1 fixed-TOP event, bit 2+i channel i match |

## Verification
A flag clear and a new event for the same flag can fall in one cycle. So can a compare-buffer write and the bottom reload. The bench forces the first case by writing all-ones to `flag_clr` in the very tick where `count` is zero, and then expects the overflow flag to read set. It forces the second case by rewriting channel 0's buffer in the middle of a period, and then expects the turn at the old TOP before the new value shows up in the next period. Random stimulus hits both collisions often, and a cycle-accurate reference model built from the requirements judges every cycle.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;

    localparam int CNT_W      = 16;
    localparam int CH_DEFAULT = 3;

    // flag vector layout
    localparam int FLG_OVF    = 0;
    localparam int FLG_FIXTOP = 1;
    localparam int FLG_CMP0   = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        OM_OFF_A  = 2'd0,
        OM_OFF_B  = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } out_mode_e;

    typedef struct packed {
        logic down;
        cnt_t value;
    } slope_state_t;

    // one step of the dual-slope sequence
    function automatic slope_state_t slope_next(slope_state_t cur, cnt_t top);
        slope_state_t nxt;
        nxt = cur;
        if (cur.value == '0) begin
            nxt.down  = 1'b0;
            nxt.value = (top == '0) ? '0 : cnt_t'(1);
        end else if (!cur.down && cur.value >= top) begin
            nxt.down  = 1'b1;
            nxt.value = cur.value - 1'b1;
        end else if (cur.down) begin
            nxt.value = cur.value - 1'b1;
        end else begin
            nxt.value = cur.value + 1'b1;
        end
        return nxt;
    endfunction

    // pin level taken on a compare match
    function automatic logic pin_on_match(out_mode_e m, logic down);
        return (m == OM_NONINV) ? down : ~down;
    endfunction

endpackage

// File: rtl/dspwm_counter.sv
module dspwm_counter
    import dspwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic top_sel,
    input  logic fix_we,
    input  cnt_t fix_wdata,
    input  cnt_t cmp_a,
    output cnt_t count,
    output logic count_down,
    output logic at_bottom,
    output logic at_top
);

    cnt_t         fix_q;
    cnt_t         top_val;
    slope_state_t st_q;

    always_comb top_val = top_sel ? cmp_a : fix_q;

    always_ff @(posedge clk) begin
        if (rst)         fix_q <= '0;
        else if (fix_we) fix_q <= fix_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)       st_q <= '0;
        else if (tick) st_q <= slope_next(st_q, top_val);
    end

    assign count      = st_q.value;
    assign count_down = st_q.down;
    assign at_bottom  = tick && (st_q.value == '0);
    assign at_top     = tick && !st_q.down && (st_q.value == top_val) && (st_q.value != '0);

    // R1
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st_q));

    // R1
    top_reverse_chk: assert property (@(posedge clk) disable iff (rst)
        at_top |=> (count_down && count == $past(count) - 1'b1));

    // R1
    bottom_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (at_bottom && top_val != '0) |=> (count == cnt_t'(1) && !count_down));

endmodule

// File: rtl/dspwm_channel.sv
module dspwm_channel
    import dspwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  cnt_t       count,
    input  logic       count_down,
    input  logic [1:0] mode_bits,
    input  logic       wr_en,
    input  cnt_t       wr_data,
    output cnt_t       cmp_live,
    output logic       hit,
    output logic       pin
);

    cnt_t      buf_q;
    cnt_t      act_q;
    logic      pin_q;
    logic      reload;
    out_mode_e mode;

    assign mode   = out_mode_e'(mode_bits);
    assign reload = tick && (count == '0);
    assign hit    = tick && (count == act_q);

    always_ff @(posedge clk) begin
        if (rst)        buf_q <= '0;
        else if (wr_en) buf_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)         act_q <= '0;
        else if (reload) act_q <= buf_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                                     pin_q <= 1'b0;
        else if (mode == OM_OFF_A || mode == OM_OFF_B) pin_q <= 1'b0;
        else if (hit)                                pin_q <= pin_on_match(mode, count_down);
    end

    assign cmp_live = act_q;
    assign pin      = pin_q;

    // R3
    live_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick && count == '0) |=> $stable(act_q));

    // R3
    buffer_capture_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (buf_q == $past(wr_data)));

    // R7
    off_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_bits[1] |=> !pin_q);

endmodule

// File: rtl/dspwm_flags.sv
module dspwm_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flags
);

    logic [N-1:0] flg_q;

    always_ff @(posedge clk) begin
        if (rst) flg_q <= '0;
        else     flg_q <= (flg_q & ~clr_req) | set_ev;
    end

    assign flags = flg_q;

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_ev) |=> ((flg_q & $past(set_ev)) == $past(set_ev)));

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_req & ~set_ev)) |=> ((flg_q & $past(clr_req & ~set_ev)) == '0));

endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer
    import dspwm_pkg::*;
#(
    parameter int NUM_CH = CH_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  top_sel,
    input  logic                  fix_we,
    input  logic [CNT_W-1:0]      fix_wdata,
    input  logic [NUM_CH-1:0]     cmp_we,
    input  logic [CNT_W-1:0]      cmp_wdata,
    input  logic [2*NUM_CH-1:0]   out_mode,
    input  logic [NUM_CH+1:0]     flag_clr,
    output logic [CNT_W-1:0]      count,
    output logic                  count_down,
    output logic [NUM_CH-1:0]     pwm_out,
    output logic [NUM_CH+1:0]     flags
);

    localparam int NF = NUM_CH + 2;

    cnt_t            cmp_live [NUM_CH];
    logic [NUM_CH-1:0] hit;
    logic            at_bottom;
    logic            at_top;
    logic [NF-1:0]   flag_ev;

    dspwm_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .top_sel    (top_sel),
        .fix_we     (fix_we),
        .fix_wdata  (fix_wdata),
        .cmp_a      (cmp_live[0]),
        .count      (count),
        .count_down (count_down),
        .at_bottom  (at_bottom),
        .at_top     (at_top)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dspwm_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .count      (count),
            .count_down (count_down),
            .mode_bits  (out_mode[2*g +: 2]),
            .wr_en      (cmp_we[g]),
            .wr_data    (cmp_wdata),
            .cmp_live   (cmp_live[g]),
            .hit        (hit[g]),
            .pin        (pwm_out[g])
        );
    end

    always_comb begin
        flag_ev             = '0;
        flag_ev[FLG_OVF]    = at_bottom;
        flag_ev[FLG_FIXTOP] = at_top && !top_sel;
        for (int i = 0; i < NUM_CH; i++) begin
            flag_ev[FLG_CMP0 + i] = hit[i];
        end
        flag_ev[FLG_CMP0] = hit[0] | (at_top && top_sel);
    end

    dspwm_flags #(.N(NF)) u_flg (
        .clk     (clk),
        .rst     (rst),
        .set_ev  (flag_ev),
        .clr_req (flag_clr),
        .flags   (flags)
    );

    // R4
    ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        at_bottom |=> flags[FLG_OVF]);

    // R5
    top_route_chk: assert property (@(posedge clk) disable iff (rst)
        (at_top && !top_sel) |=> flags[FLG_FIXTOP]);

    // R5
    top_cha_chk: assert property (@(posedge clk) disable iff (rst)
        (at_top && top_sel) |=> flags[FLG_CMP0]);

endmodule

// File: tb/tb_dspwm_timer.sv
module tb_dspwm_timer;

    localparam int NCH = 3;
    localparam int W   = 16;
    localparam int NF  = NCH + 2;

    logic            clk = 1'b0;
    logic            rst;
    logic            tick;
    logic            top_sel;
    logic            fix_we;
    logic [W-1:0]    fix_wdata;
    logic [NCH-1:0]  cmp_we;
    logic [W-1:0]    cmp_wdata;
    logic [2*NCH-1:0] out_mode;
    logic [NF-1:0]   flag_clr;
    logic [W-1:0]    count;
    logic            count_down;
    logic [NCH-1:0]  pwm_out;
    logic [NF-1:0]   flags;

    always #4 clk = ~clk;

    dspwm_timer #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst(rst), .tick(tick), .top_sel(top_sel),
        .fix_we(fix_we), .fix_wdata(fix_wdata), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .out_mode(out_mode), .flag_clr(flag_clr),
        .count(count), .count_down(count_down), .pwm_out(pwm_out), .flags(flags)
    );

    // reference model
    logic [W-1:0]   m_cnt;
    logic           m_down;
    logic [W-1:0]   m_fix;
    logic [W-1:0]   m_buf [NCH];
    logic [W-1:0]   m_act [NCH];
    logic [NCH-1:0] m_pin;
    logic [NF-1:0]  m_flags;

    int checks = 0;
    int fails  = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic model_reset();
        m_cnt = '0; m_down = 1'b0; m_fix = '0; m_pin = '0; m_flags = '0;
        for (int i = 0; i < NCH; i++) begin m_buf[i] = '0; m_act[i] = '0; end
    endtask

    task automatic model_step();
        logic [W-1:0]  top;
        logic [NF-1:0] ev;
        logic [W-1:0]  ncnt;
        logic          ndown;
        logic [1:0]    md;
        ev    = '0;
        top   = top_sel ? m_act[0] : m_fix;
        ncnt  = m_cnt;
        ndown = m_down;
        if (tick) begin
            if (m_cnt == 0) ev[0] = 1'b1;
            if (!m_down && m_cnt == top && m_cnt != 0) begin
                if (top_sel) ev[2] = 1'b1; else ev[1] = 1'b1;
            end
            for (int i = 0; i < NCH; i++) if (m_cnt == m_act[i]) ev[2+i] = 1'b1;
            if (m_cnt == 0) begin
                ncnt = (top == 0) ? '0 : W'(1); ndown = 1'b0;
            end else if (!m_down && m_cnt >= top) begin
                ncnt = m_cnt - 1'b1; ndown = 1'b1;
            end else if (m_down) ncnt = m_cnt - 1'b1;
            else ncnt = m_cnt + 1'b1;
        end
        for (int i = 0; i < NCH; i++) begin
            md = out_mode[2*i +: 2];
            if (!md[1]) m_pin[i] = 1'b0;
            else if (tick && m_cnt == m_act[i]) m_pin[i] = (md == 2'd2) ? m_down : !m_down;
        end
        for (int i = 0; i < NCH; i++) begin
            if (tick && m_cnt == 0) m_act[i] = m_buf[i];
            if (cmp_we[i]) m_buf[i] = cmp_wdata;
        end
        if (fix_we) m_fix = fix_wdata;
        m_flags = (m_flags & ~flag_clr) | ev;
        m_cnt   = ncnt;
        m_down  = ndown;
    endtask

    task automatic compare_all();
        chk("R1 count", 32'(count), 32'(m_cnt));
        chk("R1 slope", 32'(count_down), 32'(m_down));
        chk("R7 pins", 32'(pwm_out), 32'(m_pin));
        chk("R4 overflow flag", 32'(flags[0]), 32'(m_flags[0]));
        chk("R5 fixed-top flag", 32'(flags[1]), 32'(m_flags[1]));
        chk("R6 R8 compare flags", 32'(flags[NF-1:2]), 32'(m_flags[NF-1:2]));
    endtask

    task automatic strobes_off();
        fix_we = 1'b0; cmp_we = '0; flag_clr = '0;
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        strobes_off();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; strobes_off();
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic write_cmp(int ch, int val);
        tick = 1'b0; cmp_we = '0; cmp_we[ch] = 1'b1; cmp_wdata = W'(val);
        step();
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int peak;
        void'($urandom(32'd2024));
        rst = 1'b1; tick = 1'b0; top_sel = 1'b0; fix_wdata = '0; cmp_wdata = '0;
        out_mode = '0; strobes_off();
        do_reset();

        // R9 reset state
        chk("R9 count", 32'(count), 0);
        chk("R9 slope", 32'(count_down), 0);
        chk("R9 pins", 32'(pwm_out), 0);
        chk("R9 flags", 32'(flags), 0);

        // fixed TOP of 5, channel 2 compare above TOP
        out_mode = {2'd2, 2'd3, 2'd2};
        fix_we = 1'b1; fix_wdata = W'(5); step();
        write_cmp(0, 2); write_cmp(1, 3); write_cmp(2, 7);
        tick = 1'b1;
        for (int k = 0; k < 12; k++) step();
        tick = 1'b0; flag_clr = '1; step();
        chk("R8 clear without event", 32'(flags), 0);
        peak = 0; tick = 1'b1;
        for (int k = 0; k < 20; k++) begin
            step();
            if (int'(count) > peak) peak = int'(count);
        end
        chk("R2 fixed TOP peak", 32'(peak), 5);
        chk("R5 fixed TOP flag", 32'(flags[1]), 1);
        chk("R6 compare above TOP never matches", 32'(flags[4]), 0);
        chk("R6 compare match flag", 32'(flags[2]), 1);

        // R1 no step without tick
        tick = 1'b0;
        peak = int'(count);
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R1 held without tick", 32'(count), 32'(peak));
        end

        // R3 buffered TOP from channel 0
        do_reset();
        top_sel = 1'b1; out_mode = {2'd2, 2'd2, 2'd3};
        write_cmp(0, 4);
        tick = 1'b1; step(); step();
        cmp_we = 3'b001; cmp_wdata = W'(9); step();
        peak = 0;
        for (int k = 0; k < 40 && !count_down; k++) begin
            step();
            if (int'(count) > peak) peak = int'(count);
        end
        chk("R3 old TOP kept until bottom", 32'(peak), 4);
        for (int k = 0; k < 40 && count != 0; k++) step();
        step();
        peak = 0;
        for (int k = 0; k < 40 && !count_down; k++) begin
            step();
            if (int'(count) > peak) peak = int'(count);
        end
        chk("R2 channel 0 TOP after reload", 32'(peak), 9);
        chk("R5 TOP event on channel 0 flag", 32'(flags[2]), 1);

        // R8 clear colliding with bottom event
        for (int k = 0; k < 40 && count != 0; k++) step();
        flag_clr = '1; step();
        chk("R8 event wins over clear", 32'(flags[0]), 1);
        chk("R4 overflow set at bottom", 32'(flags[0]), 1);

        // R7 disabled outputs
        out_mode = '0; step();
        chk("R7 modes 0/1 hold pins low", 32'(pwm_out), 0);

        // random phase
        for (int k = 0; k < 5000; k++) begin
            tick = ($urandom_range(3, 0) != 0);
            if ($urandom_range(9, 0) == 0) begin
                cmp_we = NCH'($urandom); cmp_wdata = W'($urandom_range(22, 0));
            end
            if ($urandom_range(29, 0) == 0) begin
                fix_we = 1'b1; fix_wdata = W'($urandom_range(20, 0));
            end
            if ($urandom_range(49, 0) == 0) top_sel = ~top_sel;
            if ($urandom_range(39, 0) == 0) out_mode = (2*NCH)'($urandom);
            if ($urandom_range(9, 0) == 0) flag_clr = NF'($urandom);
            step();
        end

        summary();
        $finish;
    end

endmodule